// File: doc/BRIEF.md
# Periodic Battery-Low Monitor

This block decides when the backup battery gets tested and keeps the result. A test starts every time main power becomes nominal, and again each time a long interval of one-second ticks has run out while main power stays up. During a test the block turns on an external comparator and waits a few cycles for it to settle. It then takes one sample of the comparator's battery-below-threshold output and stores it in a sticky low-battery flag.

The flag sits in a byte-wide flags register that a host reads through a simple address/data read port. A second bit in that register records which kind of test produced the current low reading. A low reading at power-up means the battery may not have kept the retained data, so that data is suspect. A low reading from a periodic test means the battery is near the end of its life, while the data is still good. Nothing is tested while the system runs from the battery. The interval count is dropped on entry to backup and starts again from zero at the next power-up test.

Top module: `batt_mon_top`

## Requirements
- R1: Each rising edge of `main_ok`, including the first one seen after reset, starts a test that is classed as a power-up test.
- R2: While `main_ok` stays high, a periodic test starts on the `sec_tick` pulse that completes INTERVAL_S ticks since the last power-up test or the last periodic start. The default for INTERVAL_S is 86400.
- R3: A test holds `cmp_en` high for exactly SETTLE_CYC+1 consecutive cycles. Only the value of `cmp_low` in the last of those cycles is used; its value in the settle cycles has no effect.
- R4: When a test completes, the low flag becomes 1 if the sampled `cmp_low` was 1 and becomes 0 if it was 0.
- R5: Between test completions the low flag and the origin bit keep their values, whatever `cmp_low` does.
- R6: While `main_ok` is low, no test starts and `cmp_en` stays low. A test that is running when `main_ok` falls is dropped without changing the flags, and the flags keep their values through backup.
- R7: The interval count clears while `main_ok` is low and restarts from zero at the power-up test, so a periodic test needs a full INTERVAL_S ticks after power returns.
- R8: The origin bit is 1 when the current low flag came from a power-up test and 0 when it came from a periodic test. It is 0 whenever the low flag is 0.
- R9: Reading address 0xF returns the low flag in bit 4 and the origin bit in bit 3, with every other bit at 0. Every other address reads as 0x00. After reset both flags are 0 and `cmp_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sec_tick | input | 1 | One-cycle pulse once per second |
| main_ok | input | 1 | High while main supply is nominal, low in battery backup |
| cmp_low | input | 1 | Comparator result, 1 when the battery is below threshold |
| cmp_en | output | 1 | Powers the external comparator during a test |
| reg_addr | input | ADDR_W (4) | Register read address |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |

## Verification
A vector table runs a mix of power-up and periodic tests, with the battery good or low in each. This separates the low flag from the origin bit: a low reading must switch the origin when the test kind changes, and a good reading must clear both. Directed cases move `cmp_low` one cycle either side of the sampling cycle, which shows that only the last enabled cycle counts. Other cases drop main power in the middle of a test and stop one tick short of the interval after a power cycle. These show that an aborted test changes nothing, that the count restarts, and that no test runs during backup.

// File: rtl/batt_mon_pkg.sv
package batt_mon_pkg;
  localparam int DATA_W  = 8;
  localparam int LOW_BIT = 4;
  localparam int ORG_BIT = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SAMPLE = 2'd2
  } chk_state_t;
endpackage

// File: rtl/batt_rst_sync.sv
module batt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/batt_ivl_timer.sv
module batt_ivl_timer #(
  parameter int INTERVAL_S = 86400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic main_ok,
  input  logic pu_start,
  output logic per_req
);
  localparam int CNT_W = $clog2(INTERVAL_S + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_S - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d   = cnt_q;
    per_req = 1'b0;
    cnt_en  = 1'b0;
    if (!main_ok || pu_start) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (sec_tick) begin
      cnt_en = 1'b1;
      if (cnt_q == LAST) begin
        cnt_d   = '0;
        per_req = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2: the count never passes the terminal value
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R7: backup leaves the count at zero
  p_backup_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !main_ok |=> cnt_q == '0);
endmodule

// File: rtl/batt_chk_seq.sv
module batt_chk_seq
  import batt_mon_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic main_ok,
  input  logic per_req,
  output logic pu_start,
  output logic cmp_en,
  output logic smp_en,
  output logic smp_pu
);
  localparam int SC_W = $clog2(SETTLE_CYC + 1);
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(SETTLE_CYC - 1);

  chk_state_t      state_q, state_d;
  logic [SC_W-1:0] set_cnt_q, set_cnt_d;
  logic            kind_q, kind_d;
  logic            main_q;

  assign pu_start = main_ok & ~main_q;

  always_comb begin
    state_d   = state_q;
    set_cnt_d = set_cnt_q;
    kind_d    = kind_q;
    smp_en    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (pu_start) begin
          state_d   = ST_SETTLE;
          set_cnt_d = '0;
          kind_d    = 1'b1;
        end else if (per_req) begin
          state_d   = ST_SETTLE;
          set_cnt_d = '0;
          kind_d    = 1'b0;
        end
      end
      ST_SETTLE: begin
        if (!main_ok)                 state_d = ST_IDLE;
        else if (set_cnt_q == SC_LAST) state_d = ST_SAMPLE;
        else                          set_cnt_d = set_cnt_q + 1'b1;
      end
      ST_SAMPLE: begin
        state_d = ST_IDLE;
        smp_en  = main_ok;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      set_cnt_q <= '0;
      kind_q    <= 1'b0;
      main_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      set_cnt_q <= set_cnt_d;
      kind_q    <= kind_d;
      main_q    <= main_ok;
    end
  end

  assign cmp_en = (state_q != ST_IDLE);
  assign smp_pu = kind_q;

  // R1: a power rise launches a power-up class test
  p_pu_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_start && state_q == ST_IDLE) |=> (state_q == ST_SETTLE && kind_q));
  // R3: settle counter stays inside its window
  p_settle_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_SETTLE |-> set_cnt_q < SC_W'(SETTLE_CYC));
  // R6: loss of main power ends any test
  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !main_ok |=> !cmp_en);
endmodule

// File: rtl/batt_flag_regs.sv
module batt_flag_regs
  import batt_mon_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int FLAG_ADDR = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic              smp_pu,
  input  logic              cmp_low,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_rdata
);
  logic low_q, org_q, low_d, org_d;

  always_comb begin
    low_d = cmp_low;
    org_d = cmp_low & smp_pu;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= 1'b0;
      org_q <= 1'b0;
    end else if (smp_en) begin
      low_q <= low_d;
      org_q <= org_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(FLAG_ADDR)) begin
      reg_rdata[LOW_BIT] = low_q;
      reg_rdata[ORG_BIT] = org_q;
    end
  end

  // R4: a completed test stores the sampled comparator value
  p_low_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |=> low_q == $past(cmp_low));
  // R5: flags hold between completions
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable({low_q, org_q}));
  // R8: origin is only set alongside the low flag
  p_org_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    org_q |-> low_q);
endmodule

// File: rtl/batt_mon_top.sv
module batt_mon_top #(
  parameter int INTERVAL_S = 86400,
  parameter int SETTLE_CYC = 4,
  parameter int ADDR_W     = 4,
  parameter int FLAG_ADDR  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              main_ok,
  input  logic              cmp_low,
  output logic              cmp_en,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_rdata
);
  logic rst_sync_n, pu_start, per_req, smp_en, smp_pu;

  batt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  batt_ivl_timer #(.INTERVAL_S(INTERVAL_S)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .sec_tick(sec_tick), .main_ok(main_ok),
    .pu_start(pu_start), .per_req(per_req)
  );

  batt_chk_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .main_ok(main_ok), .per_req(per_req),
    .pu_start(pu_start), .cmp_en(cmp_en), .smp_en(smp_en), .smp_pu(smp_pu)
  );

  batt_flag_regs #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .smp_en(smp_en), .smp_pu(smp_pu),
    .cmp_low(cmp_low), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
  );
endmodule

// File: tb/test_batt_mon_top.sv
module test_batt_mon_top;
  localparam int IV = 5;
  localparam int SC = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       main_ok = 1'b0;
  logic       cmp_low = 1'b0;
  logic       cmp_en;
  logic [3:0] reg_addr = 4'hF;
  logic [7:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int en_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  batt_mon_top #(.INTERVAL_S(IV), .SETTLE_CYC(SC)) i_batt_mon_top (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .main_ok(main_ok),
    .cmp_low(cmp_low), .cmp_en(cmp_en), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata)
  );

  always @(negedge clk) if (cmp_en) en_cnt++;

  // {periodic, cmp_low, expected low flag, expected origin}
  localparam logic [3:0] VEC [8] = '{
    4'b0111, 4'b1000, 4'b1110, 4'b0000,
    4'b0111, 4'b1110, 4'b1000, 4'b0000
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic read_flags(output logic [7:0] v);
    reg_addr = 4'hF;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic tick();
    @(posedge clk); #1 sec_tick = 1'b1;
    @(posedge clk); #1 sec_tick = 1'b0;
  endtask

  task automatic power_cycle();
    @(posedge clk); #1 main_ok = 1'b0;
    repeat (3) @(posedge clk);
    #1 main_ok = 1'b1;
    repeat (10) @(posedge clk);
    #1;
  endtask

  task automatic periodic();
    repeat (IV) tick();
    repeat (8) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R9 reset state
    read_flags(v);
    chk(v == 8'h00, "R9 reset flags", v, 0);
    chk(cmp_en == 1'b0, "R9 reset cmp_en", cmp_en, 0);

    // R1 first power-up after reset; R3 enable length
    cmp_low = 1'b1; en_cnt = 0;
    @(posedge clk); #1 main_ok = 1'b1;
    repeat (10) @(posedge clk);
    read_flags(v);
    chk(v == 8'h18, "R1 first power-up low", v, 8'h18);
    chk(en_cnt == SC + 1, "R3 enable cycles", en_cnt, SC + 1);

    // table walk: R2 R4 R8
    for (int i = 0; i < 8; i++) begin
      cmp_low = VEC[i][2];
      if (VEC[i][3]) periodic(); else power_cycle();
      read_flags(v);
      chk(v[4] == VEC[i][1], $sformatf("R4 vec %0d low", i), v[4], VEC[i][1]);
      chk(v[3] == VEC[i][0], $sformatf("R8 vec %0d origin", i), v[3], VEC[i][0]);
    end

    // R9 other address reads zero with low flag set
    cmp_low = 1'b1; power_cycle();
    reg_addr = 4'h3; @(negedge clk);
    chk(reg_rdata == 8'h00, "R9 other address", reg_rdata, 0);

    // R5 sticky: comparator goes good, fewer ticks than the interval
    cmp_low = 1'b0;
    repeat (IV - 1) tick();
    repeat (6) @(posedge clk);
    read_flags(v);
    chk(v == 8'h18, "R5 sticky", v, 8'h18);

    // R6 no tests in backup, flags kept
    @(posedge clk); #1 main_ok = 1'b0; en_cnt = 0;
    repeat (3 * IV) tick();
    read_flags(v);
    chk(en_cnt == 0, "R6 no enable in backup", en_cnt, 0);
    chk(v == 8'h18, "R6 flags kept in backup", v, 8'h18);

    // R6 abort in mid-test
    @(posedge clk); #1 main_ok = 1'b1;
    repeat (2) @(posedge clk);
    #1 main_ok = 1'b0;
    repeat (4) @(posedge clk);
    read_flags(v);
    chk(v == 8'h18, "R6 aborted test", v, 8'h18);
    chk(cmp_en == 1'b0, "R6 enable off after abort", cmp_en, 0);

    // R7: good power-up, then IV-1 ticks with low battery: no test
    cmp_low = 1'b0; power_cycle();
    repeat (IV - 1) tick();
    @(posedge clk); #1 main_ok = 1'b0;
    @(posedge clk); #1 main_ok = 1'b1;
    repeat (10) @(posedge clk);
    #1 cmp_low = 1'b1;
    repeat (IV - 1) tick();
    repeat (6) @(posedge clk);
    read_flags(v);
    chk(v == 8'h00, "R7 count restarted", v, 0);
    tick(); repeat (8) @(posedge clk);
    read_flags(v);
    chk(v == 8'h10, "R7 full interval test", v, 8'h10);

    // R3 sampling point: low only in settle cycles -> good
    @(posedge clk); #1 main_ok = 1'b0;
    repeat (3) @(posedge clk);
    #1 main_ok = 1'b1; cmp_low = 1'b1;
    repeat (SC + 1) @(posedge clk);
    #1 cmp_low = 1'b0;
    @(posedge clk); #1 cmp_low = 1'b1;
    repeat (4) @(posedge clk);
    read_flags(v);
    chk(v == 8'h00, "R3 settle value ignored", v, 0);

    // R3 sampling point: low only in last enabled cycle -> low
    @(posedge clk); #1 main_ok = 1'b0;
    repeat (3) @(posedge clk);
    #1 main_ok = 1'b1; cmp_low = 1'b0;
    repeat (SC + 1) @(posedge clk);
    #1 cmp_low = 1'b1;
    @(posedge clk); #1 cmp_low = 1'b0;
    repeat (4) @(posedge clk);
    read_flags(v);
    chk(v == 8'h18, "R3 last cycle sampled", v, 8'h18);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule